// File: doc/BRIEF.md
# Data Memory Access Stage

This stage executes the memory-format instructions of a 32-bit load/store processor. On each accepted request it decodes the instruction word, adds the sign-extended 20-bit displacement to the base register value, and then performs a word or byte load or store. The access goes either to an external word-wide RAM port or, when the address lies at or above the RAM size, to an I/O window.

The RAM port has one cycle of read latency. It has no byte enables, so a byte store to RAM becomes a read-modify-write. The stage reads the word in the request cycle. In the following cycle it raises `busy` and writes back the word with one byte lane replaced. A request presented while `busy` is high is dropped.

Load results come back one cycle after the request, together with a write-enable and the destination register index for the register file. Stores that land in the I/O window are matched against three fixed addresses, each of which produces a one-cycle strobe:

- a halt request;
- a debug value;
- a character for output.

Loads from the I/O window return zero.

Top module: `memstage_lsu`

## Requirements
- R1: A request is a memory instruction only when instr[31]=1 and instr[30]=0. A request with req_valid high that fails this test makes no RAM access, sets no ld_valid and raises no strobe.
- R2: The effective address is base_val plus instr[19:0] sign-extended to 32 bits. A RAM access presents word index = address[IDX_W+1:2] on mem_addr in the request cycle.
- R3: A load (instr[29]=0) has ld_valid high exactly one cycle after the request, with ld_idx = instr[27:24]. For a word access (instr[28]=0) to RAM, ld_data is the addressed RAM word.
- R4: A byte load (instr[28]=1) returns (word >> 8*(address mod 4)) AND 0xFF, zero-extended.
- R5: A word store (instr[29]=1, instr[28]=0) to RAM drives mem_en=1, mem_we=1 and mem_wdata=src_val in the request cycle.
- R6: A byte store to RAM reads the word in the request cycle (mem_en=1, mem_we=0). In the next cycle busy=1 and the stage writes the same index back with byte lane (address AND 3) replaced by src_val[7:0] and the other lanes unchanged. busy lasts exactly one cycle.
- R7: A request presented while busy is high is ignored: it writes nothing to RAM, sets no ld_valid and raises no strobe.
- R8: Addresses at or above RAM_BYTES cause no RAM access. Loads from these addresses return 0 with ld_valid set one cycle later.
- R9: A store to address 0xFFFF0100 pulses halt_stb for one cycle, one cycle after the request, with io_data = the stored value.
- R10: A store to 0xFFFF0104 pulses dbg_stb one cycle after the request, with io_data = the stored value.
- R11: A store to 0xFFFF0108 pulses chr_stb one cycle after the request, with io_data[7:0] = src_val[7:0]. A byte store to the I/O window zero-extends the byte into io_data and does not set busy.
- R12: I/O stores to any other address, and all I/O loads, raise no strobe. At most one strobe is high in any cycle.
- R13: While rst is high and in the cycle after it is released, busy, ld_valid and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Instruction presented this cycle |
| instr | input | 32 | Instruction word |
| base_val | input | 32 | Value of the base register |
| src_val | input | 32 | Value of the data register (store source) |
| rf_base_idx | output | 4 | Base register index for the register file read |
| rf_src_idx | output | 4 | Data register index for the register file read |
| busy | output | 1 | Read-modify-write write-back cycle in progress |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | IDX_W | RAM word index |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data, one cycle after a read |
| ld_valid | output | 1 | Load result valid (register write-enable) |
| ld_idx | output | 4 | Destination register of the load |
| ld_data | output | 32 | Load result |
| halt_stb | output | 1 | Halt request strobe |
| dbg_stb | output | 1 | Debug value strobe |
| chr_stb | output | 1 | Character output strobe |
| io_data | output | 32 | Data carried with an I/O strobe |

## Verification
If the stored byte lane is wrong, the damage shows only when the word is read back. The bench therefore reloads every word it modifies and compares all four lanes. A lost or stretched busy flag shows in the cycle after the read. It appears as a missing write-back, or as a request during that cycle reaching RAM or the load port. A fault in the address window or the offset decode appears one cycle after a store, as a wrong strobe or a wrong io_data value. A wrong load lane or a missing zero for an I/O load appears at ld_data in the same cycle that ld_valid rises.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef struct packed {
    logic        is_mem;
    logic        store;
    logic        byte_acc;
    logic [3:0]  dst;
    logic [3:0]  base;
    logic [31:0] ea;
  } lsu_access_t;

  function automatic logic [31:0] sext_disp(input logic [19:0] d);
    return {{12{d[19]}}, d};
  endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
(
  input  logic [31:0]  instr,
  input  logic [31:0]  base_val,
  output lsu_access_t  acc
);
  always_comb begin
    acc.is_mem   = instr[31] & ~instr[30];
    acc.store    = instr[29];
    acc.byte_acc = instr[28];
    acc.dst      = instr[27:24];
    acc.base     = instr[23:20];
    acc.ea       = base_val + sext_disp(instr[19:0]);
  end
endmodule

// File: rtl/lsu_byte_lane.sv
module lsu_byte_lane #(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0]         word_in,
  input  logic [$clog2(LANES)-1:0]   lane,
  input  logic [7:0]                 byte_in,
  output logic [8*LANES-1:0]         byte_out,
  output logic [8*LANES-1:0]         merged
);
  localparam int W = 8 * LANES;

  logic [W-1:0] shifted;
  always_comb begin
    shifted  = word_in >> (lane * 8);
    byte_out = {{(W-8){1'b0}}, shifted[7:0]};
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[8*g +: 8] = (lane == g[$clog2(LANES)-1:0]) ? byte_in : word_in[8*g +: 8];
  end
endmodule

// File: rtl/lsu_io_decode.sv
module lsu_io_decode #(
  parameter logic [31:0] IO_BASE    = 32'hFFFF_0000,
  parameter logic [31:0] HALT_OFS   = 32'h0000_0100,
  parameter logic [31:0] DBG_OFS    = 32'h0000_0104,
  parameter logic [31:0] CHR_OFS    = 32'h0000_0108
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic        halt_stb,
  output logic        dbg_stb,
  output logic        chr_stb,
  output logic [31:0] io_data
);
  localparam logic [31:0] HALT_ADDR = IO_BASE + HALT_OFS;
  localparam logic [31:0] DBG_ADDR  = IO_BASE + DBG_OFS;
  localparam logic [31:0] CHR_ADDR  = IO_BASE + CHR_OFS;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_stb <= 1'b0;
      dbg_stb  <= 1'b0;
      chr_stb  <= 1'b0;
      io_data  <= '0;
    end else begin
      halt_stb <= wr_en && (addr == HALT_ADDR);
      dbg_stb  <= wr_en && (addr == DBG_ADDR);
      chr_stb  <= wr_en && (addr == CHR_ADDR);
      if (wr_en) io_data <= wdata;
    end
  end

  p_strobe_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({halt_stb, dbg_stb, chr_stb}));

  p_strobe_cause_r9: assert property (@(posedge clk) disable iff (rst)
    (halt_stb || dbg_stb || chr_stb) |-> $past(wr_en));
endmodule

// File: rtl/memstage_lsu.sv
module memstage_lsu
  import lsu_pkg::*;
#(
  parameter int unsigned RAM_BYTES = 32'h0010_0000,
  parameter logic [31:0] IO_BASE   = 32'hFFFF_0000,
  localparam int IDX_W = $clog2(RAM_BYTES) - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [31:0]       instr,
  input  logic [31:0]       base_val,
  input  logic [31:0]       src_val,
  output logic [3:0]        rf_base_idx,
  output logic [3:0]        rf_src_idx,
  output logic              busy,
  output logic              mem_en,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              ld_valid,
  output logic [3:0]        ld_idx,
  output logic [31:0]       ld_data,
  output logic              halt_stb,
  output logic              dbg_stb,
  output logic              chr_stb,
  output logic [31:0]       io_data
);
  lsu_access_t acc;

  lsu_addr_gen u_agen (
    .instr    (instr),
    .base_val (base_val),
    .acc      (acc)
  );

  assign rf_base_idx = acc.base;
  assign rf_src_idx  = acc.dst;

  // request classification
  logic accept, is_io, ram_hit, io_wr, rmw_start;
  always_comb begin
    accept    = req_valid && !busy && acc.is_mem;
    is_io     = acc.ea >= RAM_BYTES;
    ram_hit   = accept && !is_io;
    io_wr     = accept && is_io && acc.store;
    rmw_start = ram_hit && acc.store && acc.byte_acc;
  end

  // pipeline state
  logic [IDX_W-1:0] rmw_idx;
  logic [1:0]       rmw_lane;
  logic [7:0]       rmw_byte;
  logic             ld_byte_q, ld_io_q;
  logic [1:0]       ld_lane_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      ld_valid  <= 1'b0;
      ld_idx    <= '0;
      ld_byte_q <= 1'b0;
      ld_io_q   <= 1'b0;
      ld_lane_q <= '0;
      rmw_idx   <= '0;
      rmw_lane  <= '0;
      rmw_byte  <= '0;
    end else begin
      busy     <= rmw_start;
      ld_valid <= accept && !acc.store;
      if (accept && !acc.store) begin
        ld_idx    <= acc.dst;
        ld_byte_q <= acc.byte_acc;
        ld_io_q   <= is_io;
        ld_lane_q <= acc.ea[1:0];
      end
      if (rmw_start) begin
        rmw_idx  <= acc.ea[IDX_W+1:2];
        rmw_lane <= acc.ea[1:0];
        rmw_byte <= src_val[7:0];
      end
    end
  end

  // lane handling for the returning word
  logic [1:0]  lane_sel;
  logic [31:0] lane_byte, lane_merged;
  assign lane_sel = busy ? rmw_lane : ld_lane_q;

  lsu_byte_lane #(.LANES(4)) u_lane (
    .word_in  (mem_rdata),
    .lane     (lane_sel),
    .byte_in  (rmw_byte),
    .byte_out (lane_byte),
    .merged   (lane_merged)
  );

  // RAM port
  always_comb begin
    if (busy) begin
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = rmw_idx;
      mem_wdata = lane_merged;
    end else begin
      mem_en    = ram_hit;
      mem_we    = ram_hit && acc.store && !acc.byte_acc;
      mem_addr  = acc.ea[IDX_W+1:2];
      mem_wdata = src_val;
    end
  end

  always_comb begin
    if (ld_io_q)        ld_data = '0;
    else if (ld_byte_q) ld_data = lane_byte;
    else                ld_data = mem_rdata;
  end

  // I/O write decode
  logic [31:0] io_wdata;
  assign io_wdata = acc.byte_acc ? {24'b0, src_val[7:0]} : src_val;

  lsu_io_decode #(.IO_BASE(IO_BASE)) u_io (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (io_wr),
    .addr     (acc.ea),
    .wdata    (io_wdata),
    .halt_stb (halt_stb),
    .dbg_stb  (dbg_stb),
    .chr_stb  (chr_stb),
    .io_data  (io_data)
  );

  p_busy_write_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (mem_en && mem_we));

  p_busy_short_r6: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  p_busy_from_read_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> $past(mem_en && !mem_we));

  p_ld_after_req_r3: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> ($past(req_valid) && !$past(busy)));

  p_no_ld_in_rmw_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> !ld_valid);
endmodule

// File: tb/memstage_lsu_tb.sv
`timescale 1ns/1ps
module memstage_lsu_tb;
  localparam int IDX_W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] instr = '0, base_val = '0, src_val = '0;
  logic [3:0] rf_base_idx, rf_src_idx, ld_idx;
  logic busy, mem_en, mem_we, ld_valid, halt_stb, dbg_stb, chr_stb;
  logic [IDX_W-1:0] mem_addr;
  logic [31:0] mem_wdata, ld_data, io_data;
  logic [31:0] mem_rdata = '0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  memstage_lsu u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .instr(instr),
    .base_val(base_val), .src_val(src_val),
    .rf_base_idx(rf_base_idx), .rf_src_idx(rf_src_idx),
    .busy(busy), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data),
    .halt_stb(halt_stb), .dbg_stb(dbg_stb), .chr_stb(chr_stb), .io_data(io_data)
  );

  logic [31:0] ram [0:255];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr[7:0]];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit st, input bit byt, input logic [3:0] ra,
                                     input logic [3:0] rb, input logic [19:0] off);
    return {2'b10, st, byt, ra, rb, off};
  endfunction

  task automatic drive(input logic [31:0] ins, input logic [31:0] b, input logic [31:0] s);
    @(negedge clk);
    req_valid = 1'b1; instr = ins; base_val = b; src_val = s;
    #1;
  endtask

  task automatic idle_next();
    @(negedge clk);
    req_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R13 busy", {31'b0, busy}, 0);
    check("R13 ld_valid", {31'b0, ld_valid}, 0);
    check("R13 strobes", {29'b0, halt_stb, dbg_stb, chr_stb}, 0);
    rst = 1'b0;
    @(negedge clk); #1;
    check("R13 after release", {28'b0, busy, ld_valid, halt_stb, dbg_stb | chr_stb}, 0);
  endtask

  task automatic t_nonmem();
    drive({2'b11, 2'b10, 4'd1, 4'd2, 20'h00100}, 32'hFFFF_0000, 32'h1);
    check("R1 bit30 set mem_en", {31'b0, mem_en}, 0);
    drive({2'b00, 2'b00, 4'd1, 4'd2, 20'h00004}, 32'h0, 32'h1);
    check("R1 bit31 clear mem_en", {31'b0, mem_en}, 0);
    idle_next();
    check("R1 no ld_valid", {31'b0, ld_valid}, 0);
    check("R1 no strobe", {29'b0, halt_stb, dbg_stb, chr_stb}, 0);
  endtask

  task automatic t_word_load();
    ram[5] = 32'hA5A5_1234;
    drive(mk(0, 0, 4'd3, 4'd7, 20'h00004), 32'h10, 32'h0);
    check("R2 mem_addr", {14'b0, mem_addr}, 5);
    check("R2 rf_base_idx", {28'b0, rf_base_idx}, 7);
    check("R2 read en", {30'b0, mem_en, mem_we}, 2'b10);
    idle_next();
    check("R3 ld_valid", {31'b0, ld_valid}, 1);
    check("R3 ld_idx", {28'b0, ld_idx}, 3);
    check("R3 ld_data", ld_data, 32'hA5A5_1234);
    @(negedge clk); #1;
    check("R3 ld_valid single", {31'b0, ld_valid}, 0);
  endtask

  task automatic t_word_store_neg();
    drive(mk(1, 0, 4'd2, 4'd1, 20'hFFFF8), 32'h40, 32'hDEAD_BEEF);
    check("R2 neg offset addr", {14'b0, mem_addr}, 14);
    check("R5 write en", {30'b0, mem_en, mem_we}, 2'b11);
    check("R5 wdata", mem_wdata, 32'hDEAD_BEEF);
    idle_next();
    check("R5 ram content", ram[14], 32'hDEAD_BEEF);
    check("R5 no ld_valid", {31'b0, ld_valid}, 0);
  endtask

  task automatic t_byte_load();
    ram[6] = 32'h4433_2211;
    drive(mk(0, 1, 4'd4, 4'd0, 20'h00002), 32'h18, 32'h0);
    idle_next();
    check("R4 lane2", ld_data, 32'h33);
    drive(mk(0, 1, 4'd4, 4'd0, 20'h00003), 32'h18, 32'h0);
    idle_next();
    check("R4 lane3", ld_data, 32'h44);
    drive(mk(0, 1, 4'd4, 4'd0, 20'h00000), 32'h18, 32'h0);
    idle_next();
    check("R4 lane0", ld_data, 32'h11);
  endtask

  task automatic t_byte_store();
    ram[8] = 32'h1122_3344;
    drive(mk(1, 1, 4'd5, 4'd0, 20'h00001), 32'h20, 32'hABCD_EF99);
    check("R6 read phase", {29'b0, mem_en, mem_we, busy}, 3'b100);
    idle_next();
    check("R6 busy", {31'b0, busy}, 1);
    check("R6 write phase", {30'b0, mem_en, mem_we}, 2'b11);
    check("R6 addr", {14'b0, mem_addr}, 8);
    check("R6 merged", mem_wdata, 32'h1122_9944);
    @(negedge clk); #1;
    check("R6 busy one cycle", {31'b0, busy}, 0);
    check("R6 ram", ram[8], 32'h1122_9944);
    drive(mk(0, 0, 4'd5, 4'd0, 20'h00000), 32'h20, 32'h0);
    idle_next();
    check("R6 reload", ld_data, 32'h1122_9944);
  endtask

  task automatic t_busy_ignore();
    ram[9] = 32'h0; ram[10] = 32'h55;
    drive(mk(1, 1, 4'd1, 4'd0, 20'h00027), 32'h0, 32'h0000_00C3);
    drive(mk(1, 0, 4'd1, 4'd0, 20'h00028), 32'h0, 32'h77);
    check("R7 busy", {31'b0, busy}, 1);
    check("R7 addr stays rmw", {14'b0, mem_addr}, 9);
    idle_next();
    check("R7 ram untouched", ram[10], 32'h55);
    check("R7 rmw done", ram[9], 32'hC300_0000);
    drive(mk(1, 1, 4'd1, 4'd0, 20'h00024), 32'h0, 32'h11);
    drive(mk(0, 0, 4'd6, 4'd0, 20'h00028), 32'h0, 32'h0);
    idle_next();
    check("R7 load dropped", {31'b0, ld_valid}, 0);
    drive(mk(1, 1, 4'd1, 4'd0, 20'h00000), 32'h0, 32'h0);
    drive(mk(1, 0, 4'd1, 4'd0, 20'h00100), 32'hFFFF_0000, 32'h9);
    idle_next();
    check("R7 strobe dropped", {31'b0, halt_stb}, 0);
  endtask

  task automatic t_io_load();
    drive(mk(0, 0, 4'd9, 4'd0, 20'h00100), 32'hFFFF_0000, 32'h0);
    check("R8 no ram", {31'b0, mem_en}, 0);
    idle_next();
    check("R8 ld_valid", {31'b0, ld_valid}, 1);
    check("R8 zero", ld_data, 32'h0);
    check("R12 load no strobe", {29'b0, halt_stb, dbg_stb, chr_stb}, 0);
    ram[0] = 32'hFFFF_FFFF;
    drive(mk(0, 1, 4'd9, 4'd0, 20'h00000), 32'h0010_0000, 32'h0);
    check("R8 boundary no ram", {31'b0, mem_en}, 0);
    idle_next();
    check("R8 boundary zero", ld_data, 32'h0);
  endtask

  task automatic t_io_strobes();
    drive(mk(1, 0, 4'd1, 4'd0, 20'h00100), 32'hFFFF_0000, 32'h1234_5678);
    check("R8 io store no ram", {31'b0, mem_en}, 0);
    idle_next();
    check("R9 halt", {29'b0, halt_stb, dbg_stb, chr_stb}, 3'b100);
    check("R9 data", io_data, 32'h1234_5678);
    @(negedge clk); #1;
    check("R9 pulse", {31'b0, halt_stb}, 0);
    drive(mk(1, 0, 4'd1, 4'd0, 20'h00004), 32'hFFFF_0100, 32'hCAFE_0001);
    idle_next();
    check("R10 dbg", {29'b0, halt_stb, dbg_stb, chr_stb}, 3'b010);
    check("R10 data", io_data, 32'hCAFE_0001);
    drive(mk(1, 1, 4'd1, 4'd0, 20'h00108), 32'hFFFF_0000, 32'h0000_0141);
    idle_next();
    check("R11 chr", {29'b0, halt_stb, dbg_stb, chr_stb}, 3'b001);
    check("R11 data", io_data, 32'h41);
    check("R11 no busy", {31'b0, busy}, 0);
  endtask

  task automatic t_io_other();
    drive(mk(1, 0, 4'd1, 4'd0, 20'h0010C), 32'hFFFF_0000, 32'h5);
    idle_next();
    check("R12 other offset", {29'b0, halt_stb, dbg_stb, chr_stb}, 0);
    drive(mk(1, 0, 4'd1, 4'd0, 20'h00100), 32'hFFFE_0000, 32'h5);
    idle_next();
    check("R12 other window", {29'b0, halt_stb, dbg_stb, chr_stb}, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 32'h0;
    t_reset();
    t_nonmem();
    t_word_load();
    t_word_store_neg();
    t_byte_load();
    t_byte_store();
    t_busy_ignore();
    t_io_load();
    t_io_strobes();
    t_io_other();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule